// File: doc/BRIEF.md
# Serial Management Register Slave

This block is the device side of the two-wire serial management bus used to configure and monitor an Ethernet transceiver. It is clocked by the management clock. Bits are sampled on its rising edges, and it splits the bidirectional data line into an input, an output and an output enable. Each frame is checked for a long run of ones, a start code, an opcode and the target device address. An accepted frame then reads or writes one 16-bit register in a small bank. The bank holds basic control, the link-ability advertisement, a vendor mode register and a register that holds the device's own bus address.

The register contents drive the rest of the device through plain outputs: control word, advertisement word, mode word and own address. The status word and a completion acknowledge from the link-negotiation logic come back in as inputs. The device address defaults to a strap input and can be rewritten over the bus. A mode bit can make write frames accept any address.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is acted on only when at least 32 consecutive ones precede it, followed by start bits 0,1 and opcode 1,0 (read) or 0,1 (write). A shorter run of ones, a wrong start code or any other opcode causes no register change and no drive.
- R2: For an accepted read, mdio_oe_o is high for exactly 17 bit periods, from the second turnaround bit through the last data bit. It drives 0 in the second turnaround bit and then the 16 register bits MSB first, each changing on the rising edge that ends the previous bit. A read changes no register.
- R3: After the start code and opcode come the 5-bit device address and then the 5-bit register number, both MSB first. A frame whose device address differs from the own address is ignored unless R5 applies.
- R4: Register 18 bits [4:0] hold the own address and the other bits read 0. After reset the own address follows strap_addr_i until register 18 is written, and the new value applies from the next frame.
- R5: When bit 3 of register 17 is 1, write frames are accepted whatever their device address. Read frames still require a match.
- R6: Register 0 resets to 16'h3100 and appears on ctrl_o. Bit 12 enables link negotiation and bit 10 isolates the data paths. Written values other than bits 15 and 9 are stored as given.
- R7: Writing 1 to register 0 bit 9 requests a negotiation restart. The bit stays 1 until an_ack_i is sampled high and then reads 0. A write of 0 to bit 9 leaves a pending request in place.
- R8: Register 4 resets to 16'h01E1, is fully writable and appears on adv_o. Writing it does not set register 0 bit 9.
- R9: A write to register 0 with bit 15 set discards the other bits of that write. It returns registers 0, 4 and 17 to their reset values and returns the own address to the strap value. Bit 15 always reads 0.
- R10: Register 1 reads status_i, register 2 reads 16'h0007, register 3 reads 16'hC0F1, register 17 resets to 0, and any other register number reads 0.
- R11: After any frame ends or is abandoned, a new run of at least 32 ones is needed before the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc_i | input | 1 | Management clock; data sampled on rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mdio_i | input | 1 | Data line as seen at the pad |
| mdio_o | output | 1 | Data driven during reads |
| mdio_oe_o | output | 1 | Pad drive enable for mdio_o |
| strap_addr_i | input | 5 | Default own address |
| status_i | input | 16 | Live status word returned by register 1 |
| an_ack_i | input | 1 | Negotiation restart taken; clears register 0 bit 9 |
| ctrl_o | output | 16 | Register 0 contents |
| adv_o | output | 16 | Register 4 contents |
| mode_o | output | 16 | Register 17 contents |
| own_addr_o | output | 5 | Address the slave currently answers to |

## Verification
A bit counter that slips by one shows as a wrong register value or a missing write on the register outputs, at the clock edge where the last data bit is taken. It also shows as the drive window opening one period early or late, within the same frame. A stale preamble count or a wrong address compare shows as a frame that is acted on when it should be ignored. The outputs are compared with a behavioural model on every clock, so such a fault appears in the first cycle after the frame where they differ. The restart bit and the soft reset are read back over the bus, so a self-clearing fault is visible in the next read.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
  typedef enum logic {ST_HUNT, ST_FRAME} rx_state_e;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  localparam logic [4:0] RA_CTRL = 5'd0;
  localparam logic [4:0] RA_STAT = 5'd1;
  localparam logic [4:0] RA_ID1  = 5'd2;
  localparam logic [4:0] RA_ID2  = 5'd3;
  localparam logic [4:0] RA_ADV  = 5'd4;
  localparam logic [4:0] RA_MODE = 5'd17;
  localparam logic [4:0] RA_SPEC = 5'd18;

  localparam int CTRL_SRST_BIT  = 15;
  localparam int CTRL_ANRST_BIT = 9;
  localparam int MODE_BYP_BIT   = 3;
endpackage

// File: rtl/mdio_frame_rx.sv
module mdio_frame_rx
  import mdio_mgmt_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DW      = 16,
  parameter int AW      = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mdio_i,
  output logic          mdio_o,
  output logic          mdio_oe_o,
  input  logic [AW-1:0] own_addr_i,
  input  logic          wr_any_i,
  output logic [AW-1:0] reg_addr_o,
  input  logic [DW-1:0] rd_data_i,
  output logic          wr_en_o,
  output logic [DW-1:0] wr_data_o
);
  localparam int PRE_W   = $clog2(PRE_LEN + 1);
  localparam int HDR_W   = 2 + 2 * AW;
  localparam int FRM_LEN = 4 + 2 * AW + 2 + DW;
  localparam int CNT_W   = $clog2(FRM_LEN);
  localparam logic [CNT_W-1:0] IDX_HDR_END = CNT_W'(3 + 2 * AW);
  localparam logic [CNT_W-1:0] IDX_TA1     = CNT_W'(4 + 2 * AW);
  localparam logic [CNT_W-1:0] IDX_LAST    = CNT_W'(FRM_LEN - 1);

  rx_state_e        state_q;
  logic [PRE_W-1:0] ones_q;
  logic [CNT_W-1:0] cnt_q;
  logic [HDR_W-2:0] hdr_q;
  logic [DW-1:0]    sh_q;
  logic             is_rd_q;

  logic [HDR_W-1:0] hdr_nxt;
  logic [1:0]       op;
  logic [AW-1:0]    phy;
  logic             hdr_ok;

  assign hdr_nxt = {hdr_q, mdio_i};
  assign op      = hdr_nxt[HDR_W-1 -: 2];
  assign phy     = hdr_nxt[2*AW-1 -: AW];
  assign hdr_ok  = (op == OP_RD && phy == own_addr_i) ||
                   (op == OP_WR && (phy == own_addr_i || wr_any_i));

  assign reg_addr_o = hdr_q[AW-1:0];
  assign wr_en_o    = (state_q == ST_FRAME) && (cnt_q == IDX_LAST) && !is_rd_q;
  assign wr_data_o  = {sh_q[DW-2:0], mdio_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_HUNT;
      ones_q    <= '0;
      cnt_q     <= '0;
      hdr_q     <= '0;
      sh_q      <= '0;
      is_rd_q   <= 1'b0;
      mdio_o    <= 1'b0;
      mdio_oe_o <= 1'b0;
    end else begin
      unique case (state_q)
        ST_HUNT: begin
          if (mdio_i) begin
            if (ones_q != PRE_W'(PRE_LEN)) ones_q <= ones_q + 1'b1;
          end else if (ones_q == PRE_W'(PRE_LEN)) begin
            state_q <= ST_FRAME;      // this zero is the first start bit
            cnt_q   <= CNT_W'(1);
            ones_q  <= '0;
          end else begin
            ones_q <= '0;
          end
        end
        ST_FRAME: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(1) && !mdio_i) state_q <= ST_HUNT;
          if (cnt_q >= CNT_W'(2) && cnt_q <= IDX_HDR_END) hdr_q <= hdr_nxt[HDR_W-2:0];
          if (cnt_q == IDX_HDR_END) begin
            is_rd_q <= (op == OP_RD);
            if (!hdr_ok) state_q <= ST_HUNT;
          end
          if (cnt_q == IDX_TA1 && is_rd_q) begin
            mdio_oe_o <= 1'b1;
            mdio_o    <= 1'b0;
            sh_q      <= rd_data_i;
          end
          if (cnt_q > IDX_TA1 && cnt_q < IDX_LAST) begin
            if (is_rd_q) begin
              mdio_o <= sh_q[DW-1];
              sh_q   <= {sh_q[DW-2:0], 1'b0};
            end else begin
              sh_q <= {sh_q[DW-2:0], mdio_i};
            end
          end
          if (cnt_q == IDX_LAST) begin
            state_q   <= ST_HUNT;
            mdio_oe_o <= 1'b0;
            mdio_o    <= 1'b0;
          end
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
  import mdio_mgmt_pkg::*;
#(
  parameter int            DW       = 16,
  parameter int            AW       = 5,
  parameter logic [DW-1:0] CTRL_RST = 16'h3100,
  parameter logic [DW-1:0] ADV_RST  = 16'h01E1,
  parameter logic [DW-1:0] MODE_RST = 16'h0000,
  parameter logic [DW-1:0] ID1      = 16'h0007,
  parameter logic [DW-1:0] ID2      = 16'hC0F1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] rd_data_o,
  input  logic [DW-1:0] status_i,
  input  logic [AW-1:0] strap_addr_i,
  input  logic          an_ack_i,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] adv_o,
  output logic [DW-1:0] mode_o,
  output logic [AW-1:0] own_addr_o
);
  localparam logic [DW-1:0] SRST_M    = DW'(1) << CTRL_SRST_BIT;
  localparam logic [DW-1:0] ANRST_M   = DW'(1) << CTRL_ANRST_BIT;
  localparam logic [DW-1:0] SC_M      = SRST_M | ANRST_M;
  localparam logic [DW-1:0] CTRL_INIT = CTRL_RST & ~SC_M;

  logic [DW-1:0] ctrl_q, adv_q, mode_q;
  logic [AW-1:0] own_q;
  logic          own_ld_q;
  logic          wr_ctrl, srst, an_keep;

  assign wr_ctrl = wr_en_i && (addr_i == RA_CTRL);
  assign srst    = wr_ctrl && wr_data_i[CTRL_SRST_BIT];
  assign an_keep = ctrl_q[CTRL_ANRST_BIT] && !an_ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= CTRL_INIT;
      adv_q    <= ADV_RST;
      mode_q   <= MODE_RST;
      own_q    <= '0;
      own_ld_q <= 1'b0;
    end else if (srst) begin
      ctrl_q   <= CTRL_INIT;
      adv_q    <= ADV_RST;
      mode_q   <= MODE_RST;
      own_q    <= '0;
      own_ld_q <= 1'b0;
    end else begin
      if (wr_ctrl)
        ctrl_q <= (wr_data_i & ~SC_M) |
                  ((wr_data_i[CTRL_ANRST_BIT] || an_keep) ? ANRST_M : '0);
      else
        ctrl_q[CTRL_ANRST_BIT] <= an_keep;
      if (wr_en_i && addr_i == RA_ADV)  adv_q  <= wr_data_i;
      if (wr_en_i && addr_i == RA_MODE) mode_q <= wr_data_i;
      if (wr_en_i && addr_i == RA_SPEC) begin
        own_q    <= wr_data_i[AW-1:0];
        own_ld_q <= 1'b1;
      end
    end
  end

  // strap value is used until software writes an address
  assign own_addr_o = own_ld_q ? own_q : strap_addr_i;
  assign ctrl_o     = ctrl_q;
  assign adv_o      = adv_q;
  assign mode_o     = mode_q;

  always_comb begin
    unique case (addr_i)
      RA_CTRL: rd_data_o = ctrl_q;
      RA_STAT: rd_data_o = status_i;
      RA_ID1:  rd_data_o = ID1;
      RA_ID2:  rd_data_o = ID2;
      RA_ADV:  rd_data_o = adv_q;
      RA_MODE: rd_data_o = mode_q;
      RA_SPEC: rd_data_o = DW'(own_addr_o);
      default: rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_mgmt_pkg::*;
#(
  parameter int            PRE_LEN  = 32,
  parameter int            DW       = 16,
  parameter int            AW       = 5,
  parameter logic [DW-1:0] CTRL_RST = 16'h3100,
  parameter logic [DW-1:0] ADV_RST  = 16'h01E1,
  parameter logic [DW-1:0] MODE_RST = 16'h0000,
  parameter logic [DW-1:0] ID1      = 16'h0007,
  parameter logic [DW-1:0] ID2      = 16'hC0F1
) (
  input  logic          mdc_i,
  input  logic          rst_ni,
  input  logic          mdio_i,
  output logic          mdio_o,
  output logic          mdio_oe_o,
  input  logic [AW-1:0] strap_addr_i,
  input  logic [DW-1:0] status_i,
  input  logic          an_ack_i,
  output logic [DW-1:0] ctrl_o,
  output logic [DW-1:0] adv_o,
  output logic [DW-1:0] mode_o,
  output logic [AW-1:0] own_addr_o
);
  logic [AW-1:0] reg_addr;
  logic [DW-1:0] rd_data, wr_data;
  logic          wr_en;

  mdio_frame_rx #(.PRE_LEN(PRE_LEN), .DW(DW), .AW(AW)) u_rx (
    .clk_i      (mdc_i),
    .rst_ni     (rst_ni),
    .mdio_i     (mdio_i),
    .mdio_o     (mdio_o),
    .mdio_oe_o  (mdio_oe_o),
    .own_addr_i (own_addr_o),
    .wr_any_i   (mode_o[MODE_BYP_BIT]),
    .reg_addr_o (reg_addr),
    .rd_data_i  (rd_data),
    .wr_en_o    (wr_en),
    .wr_data_o  (wr_data)
  );

  mdio_reg_bank #(
    .DW(DW), .AW(AW), .CTRL_RST(CTRL_RST), .ADV_RST(ADV_RST),
    .MODE_RST(MODE_RST), .ID1(ID1), .ID2(ID2)
  ) u_bank (
    .clk_i        (mdc_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en),
    .addr_i       (reg_addr),
    .wr_data_i    (wr_data),
    .rd_data_o    (rd_data),
    .status_i     (status_i),
    .strap_addr_i (strap_addr_i),
    .an_ack_i     (an_ack_i),
    .ctrl_o       (ctrl_o),
    .adv_o        (adv_o),
    .mode_o       (mode_o),
    .own_addr_o   (own_addr_o)
  );
endmodule

// File: rtl/mdio_mgmt_slave_chk.sv
module mdio_mgmt_slave_chk (
  input logic        mdc_i,
  input logic        rst_ni,
  input logic        mdio_o,
  input logic        mdio_oe_o,
  input logic [15:0] adv_o,
  input logic [15:0] mode_o
);
  logic [4:0] oe_run_q;

  always_ff @(posedge mdc_i or negedge rst_ni) begin
    if (!rst_ni) oe_run_q <= '0;
    else         oe_run_q <= mdio_oe_o ? oe_run_q + 1'b1 : '0;
  end

  a_r2_ta_zero: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    $rose(mdio_oe_o) |-> !mdio_o);

  a_r2_drive_len: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    $fell(mdio_oe_o) |-> $past(oe_run_q) == 5'd16);

  a_r2_max_len: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    mdio_oe_o |-> oe_run_q < 5'd17);

  a_r2_read_quiet: assert property (@(posedge mdc_i) disable iff (!rst_ni)
    (mdio_oe_o && $past(mdio_oe_o)) |-> ($stable(adv_o) && $stable(mode_o)));
endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk u_chk (
  .mdc_i     (mdc_i),
  .rst_ni    (rst_ni),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o),
  .adv_o     (adv_o),
  .mode_o    (mode_o)
);

// File: tb/mdio_mgmt_slave_test.sv
module mdio_mgmt_slave_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0, mdio_i = 1'b0, an_ack = 1'b0;
  logic [4:0]  strap = 5'h0A;
  logic [15:0] status = 16'h782D;
  logic        mdio_o, mdio_oe_o;
  logic [15:0] ctrl_o, adv_o, mode_o;
  logic [4:0]  own_addr_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_mgmt_slave uut (
    .mdc_i(clk), .rst_ni(rst_n), .mdio_i(mdio_i), .mdio_o(mdio_o),
    .mdio_oe_o(mdio_oe_o), .strap_addr_i(strap), .status_i(status),
    .an_ack_i(an_ack), .ctrl_o(ctrl_o), .adv_o(adv_o), .mode_o(mode_o),
    .own_addr_o(own_addr_o)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  logic [15:0] m_ctrl, m_adv, m_mode;
  logic [4:0]  m_own;
  bit          m_ld, m_oe;

  function automatic void m_reset();
    m_ctrl = 16'h3100; m_adv = 16'h01E1; m_mode = 16'h0000;
    m_own = 5'h00; m_ld = 1'b0;
  endfunction

  function automatic logic [4:0] exp_own();
    return m_ld ? m_own : strap;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void model_write(input logic [4:0] rg, input logic [15:0] wd);
    case (rg)
      5'd0: if (wd[15]) m_reset();
            else m_ctrl = (wd & 16'h7DFF) | ((wd[9] | m_ctrl[9]) ? 16'h0200 : 16'h0000);
      5'd4:  m_adv  = wd;
      5'd17: m_mode = wd;
      5'd18: begin m_own = wd[4:0]; m_ld = 1'b1; end
      default: ;
    endcase
  endfunction

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(ctrl_o == m_ctrl, "R6 ctrl_o", 32'(ctrl_o), 32'(m_ctrl));
      chk(adv_o == m_adv, "R8 adv_o", 32'(adv_o), 32'(m_adv));
      chk(mode_o == m_mode, "R5 mode_o", 32'(mode_o), 32'(m_mode));
      chk(own_addr_o == exp_own(), "R4 own_addr_o", 32'(own_addr_o), 32'(exp_own()));
      chk(mdio_oe_o == m_oe, "R2 mdio_oe_o", 32'(mdio_oe_o), 32'(m_oe));
    end
  end

  task automatic frame(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] wd, input int pre, input logic [1:0] st,
                       output logic [15:0] rd);
    logic [31:0] bits;
    bit acc_rd, acc_wr;
    bits = {st, op, phy, rg, 2'b10, wd};
    if (op == 2'b10) bits[17:0] = '1;
    acc_rd = (pre >= 32) && (st == 2'b01) && (op == 2'b10) && (phy == exp_own());
    acc_wr = (pre >= 32) && (st == 2'b01) && (op == 2'b01) && (phy == exp_own() || m_mode[3]);
    rd = '0;
    @(negedge clk); mdio_i = 1'b0;
    @(posedge clk);
    for (int i = 0; i < pre + 32; i++) begin
      automatic int f = i - pre;
      @(negedge clk);
      if (acc_rd && f >= 16) rd[31-f] = mdio_o;
      if (acc_rd && f == 15) chk(mdio_o == 1'b0, "R2 turnaround", 32'(mdio_o), 0);
      mdio_i = (i < pre) ? 1'b1 : bits[31-f];
      @(posedge clk); #1;
      if (acc_rd) m_oe = (f >= 14 && f <= 30);
      if (acc_wr && f == 31) model_write(rg, wd);
    end
    @(negedge clk); mdio_i = 1'b0;
  endtask

  task automatic wr(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd);
    logic [15:0] dummy;
    frame(2'b01, phy, rg, wd, 32, 2'b01, dummy);
  endtask

  task automatic rd_chk(input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] exp, input string req);
    logic [15:0] got;
    frame(2'b10, phy, rg, 16'h0, 32, 2'b01, got);
    chk(got == exp, req, 32'(got), 32'(exp));
  endtask

  task automatic ack_pulse();
    @(negedge clk); an_ack = 1'b1;
    @(posedge clk); #1; m_ctrl[9] = 1'b0;
    @(negedge clk); an_ack = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] scratch;
    m_reset(); m_oe = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // reset state
    chk(ctrl_o == 16'h3100, "R6 reset ctrl", 32'(ctrl_o), 32'h3100);
    chk(adv_o == 16'h01E1, "R8 reset adv", 32'(adv_o), 32'h01E1);
    chk(own_addr_o == 5'h0A, "R4 strap addr", 32'(own_addr_o), 32'h0A);
    chk(mode_o == 16'h0, "R10 reset mode", 32'(mode_o), 0);
    chk(!mdio_oe_o, "R2 idle no drive", 32'(mdio_oe_o), 0);

    // R10 fixed and unimplemented registers
    rd_chk(5'h0A, 5'd1, 16'h782D, "R10 status read");
    status = 16'h0004;
    rd_chk(5'h0A, 5'd1, 16'h0004, "R10 status live");
    rd_chk(5'h0A, 5'd2, 16'h0007, "R10 id1");
    rd_chk(5'h0A, 5'd3, 16'hC0F1, "R10 id2");
    rd_chk(5'h0A, 5'd7, 16'h0000, "R10 unimplemented");
    rd_chk(5'h0A, 5'd18, 16'h000A, "R4 reg18 strap");

    // R6 control fields
    wr(5'h0A, 5'd0, 16'h1400);
    chk(ctrl_o[12] && ctrl_o[10], "R6 an_en+isolate", 32'(ctrl_o), 32'h1400);
    rd_chk(5'h0A, 5'd0, 16'h1400, "R6 readback");

    // R7 restart bit
    wr(5'h0A, 5'd0, 16'h1600);
    chk(ctrl_o[9] == 1'b1, "R7 restart set", 32'(ctrl_o[9]), 1);
    rd_chk(5'h0A, 5'd0, 16'h1600, "R7 pending read");
    wr(5'h0A, 5'd0, 16'h1400);
    chk(ctrl_o[9] == 1'b1, "R7 write0 keeps", 32'(ctrl_o[9]), 1);
    ack_pulse();
    rd_chk(5'h0A, 5'd0, 16'h1400, "R7 cleared by ack");

    // R8 advertisement
    wr(5'h0A, 5'd4, 16'h0DE1);
    chk(adv_o == 16'h0DE1 && !ctrl_o[9], "R8 adv no restart", 32'({ctrl_o[9], adv_o}), 32'h0DE1);

    // R3 address mismatch
    wr(5'h0B, 5'd4, 16'h1111);
    chk(adv_o == 16'h0DE1, "R3 wrong addr write", 32'(adv_o), 32'h0DE1);
    frame(2'b10, 5'h0B, 5'd4, 16'h0, 32, 2'b01, scratch);
    chk(!mdio_oe_o, "R3 wrong addr read", 32'(mdio_oe_o), 0);

    // R1 framing faults
    frame(2'b01, 5'h0A, 5'd4, 16'h2222, 31, 2'b01, scratch);
    chk(adv_o == 16'h0DE1, "R1 short preamble", 32'(adv_o), 32'h0DE1);
    frame(2'b01, 5'h0A, 5'd4, 16'h3333, 32, 2'b00, scratch);
    chk(adv_o == 16'h0DE1, "R1 bad start", 32'(adv_o), 32'h0DE1);
    frame(2'b11, 5'h0A, 5'd4, 16'h4444, 32, 2'b01, scratch);
    chk(adv_o == 16'h0DE1, "R1 bad opcode", 32'(adv_o), 32'h0DE1);
    frame(2'b01, 5'h0A, 5'd4, 16'h0C01, 40, 2'b01, scratch);
    chk(adv_o == 16'h0C01, "R1 long preamble", 32'(adv_o), 32'h0C01);

    // R11 no preamble after a frame
    frame(2'b01, 5'h0A, 5'd4, 16'h5555, 0, 2'b01, scratch);
    chk(adv_o == 16'h0C01, "R11 needs new preamble", 32'(adv_o), 32'h0C01);

    // R4 own address rewrite
    wr(5'h0A, 5'd18, 16'hFFE5);
    chk(own_addr_o == 5'h05, "R4 new addr", 32'(own_addr_o), 32'h05);
    wr(5'h0A, 5'd4, 16'h6666);
    chk(adv_o == 16'h0C01, "R4 old addr ignored", 32'(adv_o), 32'h0C01);
    rd_chk(5'h05, 5'd18, 16'h0005, "R4 reg18 readback");

    // R5 write bypass
    wr(5'h05, 5'd17, 16'h0008);
    wr(5'h1F, 5'd4, 16'h0A0A);
    chk(adv_o == 16'h0A0A, "R5 bypass write", 32'(adv_o), 32'h0A0A);
    frame(2'b10, 5'h1F, 5'd4, 16'h0, 32, 2'b01, scratch);
    chk(!mdio_oe_o, "R5 read needs match", 32'(mdio_oe_o), 0);
    rd_chk(5'h05, 5'd4, 16'h0A0A, "R5 matched read");
    wr(5'h1F, 5'd17, 16'h0000);
    wr(5'h1F, 5'd4, 16'h7777);
    chk(adv_o == 16'h0A0A, "R5 bypass off", 32'(adv_o), 32'h0A0A);

    // R9 soft reset
    wr(5'h05, 5'd0, 16'h1200);
    wr(5'h05, 5'd0, 16'h8400);
    chk(ctrl_o == 16'h3100, "R9 ctrl default", 32'(ctrl_o), 32'h3100);
    chk(adv_o == 16'h01E1 && own_addr_o == 5'h0A, "R9 adv+addr default",
        32'({own_addr_o, adv_o}), 32'h0A01E1);
    rd_chk(5'h0A, 5'd0, 16'h3100, "R9 bit15 reads 0");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule